// File: doc/BRIEF.md
# Adaptive Voltage Scaling Monitor

This block checks, at a fixed period, how fast an on-die ring oscillator runs compared with a programmed target. From that comparison it recommends whether the supply voltage should go up or down. A fractional divider turns the reference clock into microsecond ticks, and a programmable number of ticks makes one measurement interval. At the start of each interval the block waits a programmable number of idle cycles. It then opens a gate window of a programmed length in microseconds and counts oscillator edges during it. In the cycle after the window closes, it converts the count into a signed error in voltage steps.

The up and down directions are handled separately. Each has its own threshold, its own count of consecutive qualifying intervals and its own step limit. A request drives a level interrupt that stays high until software clears it. While any interrupt is pending, no new measurement result is taken in. A small set of status outputs gives the last error in steps, its direction, whether the step limit clipped it, and the step count recommended with the last request.

Top module: `avs_monitor`

## Requirements
- R1: A microsecond tick is produced by adding 1000 to an accumulator every cycle and subtracting `cfg_ref_khz` when the sum reaches it. A measurement interval is `cfg_interval_us` ticks, so two requests raised in successive intervals are `cfg_interval_us * cfg_ref_khz / 1000` cycles apart.
- R2: After an interval starts, the block waits `cfg_idle_clks + 1` cycles. It then counts the cycles in which `osc_edge` is high over a window of `cfg_gate_us` ticks. With a 1000 kHz reference and `osc_edge` held high, the count equals `cfg_gate_us`; with `osc_edge` held low, the count is 0.
- R3: The error is |target − count| / `cfg_step_div`. A divisor of 0 is treated as 1, and the result saturates at the width of the step fields. After each evaluation taken in, `stat_err` holds this error and `stat_up` is 1 when count < target.
- R4: An up request sets `irq[0]`. It can happen only when count < target and the error is strictly greater than `cfg_up_thresh`.
- R5: A down request sets `irq[1]`. It can happen only when count > target and the error is strictly greater than `cfg_dn_thresh`.
- R6: A request fires when its direction qualifies and the number of qualifying intervals immediately before it is at least the consecutive count for that direction, so 0 means the first qualifying interval fires. An interval that does not qualify clears that direction's run.
- R7: The interrupts are levels. Each bit stays set until a 1 is written to the matching bit of `irq_clr`. While any bit is set, evaluations are discarded: status, runs and interrupts keep their values.
- R8: With a request, `rec_steps` = min(error, limit for that direction). When the error exceeds that limit, `irq[2]` is set together with the request bit, and `stat_clip` reports the clip on every evaluation taken in.
- R9: After reset, `irq`, `stat_err`, `stat_up`, `stat_clip` and `rec_steps` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_edge | input | 1 | Oscillator edge indication, sampled every cycle |
| cfg_ref_khz | input | KW | Reference clock rate in kHz |
| cfg_interval_us | input | UW | Measurement interval in microseconds |
| cfg_gate_us | input | UW | Gate window length in microseconds |
| cfg_idle_clks | input | IW | Idle cycles before the gate window |
| cfg_target | input | CW | Target edge count |
| cfg_step_div | input | CW | Edges per voltage step (0 acts as 1) |
| cfg_up_thresh | input | SW | Error must exceed this to step up |
| cfg_dn_thresh | input | SW | Error must exceed this to step down |
| cfg_up_cons | input | NW | Prior qualifying intervals needed for an up request |
| cfg_dn_cons | input | NW | Prior qualifying intervals needed for a down request |
| cfg_up_limit | input | SW | Largest step count recommended upward |
| cfg_dn_limit | input | SW | Largest step count recommended downward |
| irq_clr | input | 3 | Write-one-to-clear for each interrupt bit |
| irq | output | 3 | Bit 0 up request, bit 1 down request, bit 2 limit clipped |
| stat_err | output | SW | Last error in steps |
| stat_up | output | 1 | Last error called for stepping up |
| stat_clip | output | 1 | Last error exceeded its direction's limit |
| rec_steps | output | SW | Step count recommended with the last request |

## Verification
The bench tests the thresholds exactly at the boundary, where error equals the threshold and must not fire. A comparison that is off by one would raise a request there. It breaks a run of qualifying intervals with a single interval that does not qualify; a design that does not clear the run would fire one interval too early. It holds an interrupt pending while the measured conditions change, so a design that does not mask would update status or raise a second line. Random configurations, including a divisor of 0 and limits below the error, check the clip flag and the recommended step count. Interval period checks at two reference rates, one of them not an integer number of cycles per microsecond, catch a divider that rounds the tick rate.

// File: rtl/avs_monitor.sv
module avs_monitor #(
  parameter int CW = 16,
  parameter int UW = 16,
  parameter int KW = 16,
  parameter int IW = 8,
  parameter int SW = 8,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_edge,
  input  logic [KW-1:0] cfg_ref_khz,
  input  logic [UW-1:0] cfg_interval_us,
  input  logic [UW-1:0] cfg_gate_us,
  input  logic [IW-1:0] cfg_idle_clks,
  input  logic [CW-1:0] cfg_target,
  input  logic [CW-1:0] cfg_step_div,
  input  logic [SW-1:0] cfg_up_thresh,
  input  logic [SW-1:0] cfg_dn_thresh,
  input  logic [NW-1:0] cfg_up_cons,
  input  logic [NW-1:0] cfg_dn_cons,
  input  logic [SW-1:0] cfg_up_limit,
  input  logic [SW-1:0] cfg_dn_limit,
  input  logic [2:0]    irq_clr,
  output logic [2:0]    irq,
  output logic [SW-1:0] stat_err,
  output logic          stat_up,
  output logic          stat_clip,
  output logic [SW-1:0] rec_steps
);
  localparam logic [KW:0]   KHZ_PER_MHZ = (KW+1)'(1000);
  localparam logic [CW-1:0] STEP_MAX    = CW'((1 << SW) - 1);

  typedef enum logic [1:0] {S_WAIT, S_IDLE, S_GATE, S_EVAL} phase_t;
  phase_t phase;

  logic [KW:0]   acc;
  logic [KW:0]   acc_sum;
  logic          tick;
  logic [UW-1:0] ucnt;
  logic          ivl_end;
  logic [UW-1:0] pcnt;
  logic [CW-1:0] ecnt;
  logic [NW-1:0] up_run, dn_run;

  assign acc_sum = acc + KHZ_PER_MHZ;
  assign tick    = acc_sum >= {1'b0, cfg_ref_khz};
  assign ivl_end = tick && ({1'b0, ucnt} + 1'b1 >= {1'b0, cfg_interval_us});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      ucnt <= '0;
    end else begin
      if (cfg_ref_khz == '0) acc <= '0;
      else                   acc <= tick ? acc_sum - {1'b0, cfg_ref_khz} : acc_sum;
      if (tick) ucnt <= ivl_end ? '0 : ucnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= S_WAIT;
      pcnt  <= '0;
      ecnt  <= '0;
    end else begin
      case (phase)
        S_WAIT: if (ivl_end) begin
          phase <= S_IDLE;
          pcnt  <= '0;
          ecnt  <= '0;
        end
        S_IDLE: if (pcnt >= UW'(cfg_idle_clks)) begin
          phase <= S_GATE;
          pcnt  <= '0;
        end else pcnt <= pcnt + 1'b1;
        S_GATE: begin
          ecnt <= ecnt + CW'(osc_edge);
          if (tick) begin
            if ({1'b0, pcnt} + 1'b1 >= {1'b0, cfg_gate_us}) phase <= S_EVAL;
            else pcnt <= pcnt + 1'b1;
          end
        end
        default: phase <= S_WAIT;
      endcase
    end
  end

  logic          below;
  logic [CW-1:0] diff, quot, divisor;
  logic [SW-1:0] mag, lim;
  logic          up_q, dn_q, up_fire, dn_fire, clip, pending, take;

  assign below   = ecnt < cfg_target;
  assign diff    = below ? cfg_target - ecnt : ecnt - cfg_target;
  assign divisor = (cfg_step_div == '0) ? CW'(1) : cfg_step_div;
  assign quot    = diff / divisor;
  assign mag     = (quot > STEP_MAX) ? STEP_MAX[SW-1:0] : quot[SW-1:0];
  assign up_q    = below && (mag > cfg_up_thresh);
  assign dn_q    = !below && (mag > cfg_dn_thresh);
  assign up_fire = up_q && (up_run >= cfg_up_cons);
  assign dn_fire = dn_q && (dn_run >= cfg_dn_cons);
  assign lim     = below ? cfg_up_limit : cfg_dn_limit;
  assign clip    = mag > lim;
  assign pending = |irq;
  assign take    = (phase == S_EVAL) && !pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq       <= '0;
      stat_err  <= '0;
      stat_up   <= 1'b0;
      stat_clip <= 1'b0;
      rec_steps <= '0;
      up_run    <= '0;
      dn_run    <= '0;
    end else if (take) begin
      stat_err  <= mag;
      stat_up   <= below;
      stat_clip <= clip;
      up_run    <= (up_q && !up_fire) ? up_run + 1'b1 : '0;
      dn_run    <= (dn_q && !dn_fire) ? dn_run + 1'b1 : '0;
      if (up_fire || dn_fire) begin
        irq       <= {clip, dn_fire, up_fire};
        rec_steps <= clip ? lim : mag;
      end
    end else begin
      irq <= irq & ~irq_clr;
    end
  end

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    |(irq & ~irq_clr) |=> ((irq & $past(irq & ~irq_clr)) == $past(irq & ~irq_clr)));

  assert_status_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> ($stable(stat_err) && $stable(stat_up) && $stable(stat_clip)));

  assert_one_direction_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq[1:0]));

  assert_up_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> (rec_steps <= cfg_up_limit && stat_up));

  assert_dn_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[1]) |-> (rec_steps <= cfg_dn_limit && !stat_up));

  assert_clip_with_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[2]) |-> (irq[0] || irq[1]));

  assert_up_threshold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> (stat_err > cfg_up_thresh));

  assert_dn_threshold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[1]) |-> (stat_err > cfg_dn_thresh));
endmodule

// File: tb/avs_monitor_test.sv
module avs_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_edge = 1'b1;
  logic [15:0] cfg_ref_khz = 16'd1000, cfg_interval_us = 16'd40, cfg_gate_us = 16'd10;
  logic [7:0]  cfg_idle_clks = 8'd3;
  logic [15:0] cfg_target = 16'd0, cfg_step_div = 16'd1;
  logic [7:0]  cfg_up_thresh = 8'd0, cfg_dn_thresh = 8'd0;
  logic [3:0]  cfg_up_cons = 4'd0, cfg_dn_cons = 4'd0;
  logic [7:0]  cfg_up_limit = 8'd255, cfg_dn_limit = 8'd255;
  logic [2:0]  irq_clr = 3'b000;
  logic [2:0]  irq;
  logic [7:0]  stat_err, rec_steps;
  logic        stat_up, stat_clip;

  int tests = 0, fails = 0, cyc = 0, rel = 0;
  bit done = 0;

  avs_monitor uut (.clk, .rst_n, .osc_edge, .cfg_ref_khz, .cfg_interval_us, .cfg_gate_us,
    .cfg_idle_clks, .cfg_target, .cfg_step_div, .cfg_up_thresh, .cfg_dn_thresh,
    .cfg_up_cons, .cfg_dn_cons, .cfg_up_limit, .cfg_dn_limit, .irq_clr, .irq,
    .stat_err, .stat_up, .stat_clip, .rec_steps);

  always #2 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rel <= rst_n ? rel + 1 : 0;
  end

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_clr = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic at_point(int k);
    while (rel < k*40 + 30) @(posedge clk);
    #1;
  endtask

  function automatic int err_of(int cnt, int tgt, int dv);
    int d = (cnt > tgt) ? cnt - tgt : tgt - cnt;
    int q = d / ((dv == 0) ? 1 : dv);
    return (q > 255) ? 255 : q;
  endfunction

  task automatic expect_eval(string tag, int cnt);
    int e, lim;
    bit up, fu, fd, cl;
    e   = err_of(cnt, cfg_target, cfg_step_div);
    up  = cnt < cfg_target;
    fu  = up && e > cfg_up_thresh;
    fd  = !up && e > cfg_dn_thresh;
    lim = up ? cfg_up_limit : cfg_dn_limit;
    cl  = e > lim;
    chk({tag, " R3 err"}, stat_err, e);
    chk({tag, " R3 dir"}, stat_up, up);
    chk({tag, " R8 clip"}, stat_clip, cl);
    chk({tag, " R4 R5 irq"}, irq, (fu || fd) ? {cl, fd, fu} : 0);
    if (fu || fd) chk({tag, " R8 rec"}, rec_steps, cl ? lim : e);
  endtask

  task automatic clear_all();
    @(negedge clk); irq_clr = 3'b111;
    @(negedge clk); irq_clr = 3'b000;
  endtask

  task automatic period_of(int ref_khz, int ivl, int exp_cyc);
    int t0;
    int t1;
    cfg_ref_khz = 16'(ref_khz); cfg_interval_us = 16'(ivl);
    cfg_gate_us = 16'd1; cfg_idle_clks = 8'd0; osc_edge = 1'b0;
    cfg_target = 16'd100; cfg_up_thresh = 8'd0; cfg_up_cons = 4'd0; cfg_step_div = 16'd1;
    do_reset();
    t0 = cyc;
    while (!irq[0] && cyc < t0 + 1000) @(posedge clk);
    t0 = cyc;
    clear_all();
    while (!irq[0] && cyc < t0 + 1000) @(posedge clk);
    t1 = cyc;
    chk("R1 interval period", t1 - t0, exp_cyc);
  endtask

  initial begin
    #(4*200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R9 reset values
    chk("R9 irq", irq, 0); chk("R9 err", stat_err, 0); chk("R9 dir", stat_up, 0);
    chk("R9 clip", stat_clip, 0); chk("R9 rec", rec_steps, 0);

    // R1 interval at two reference rates
    period_of(4000, 10, 40);
    period_of(1500, 8, 12);

    // Directed checks: 1000 kHz, interval 40, gate 10, osc high -> count 10 (R2)
    cfg_ref_khz = 16'd1000; cfg_interval_us = 16'd40; cfg_gate_us = 16'd10;
    cfg_idle_clks = 8'd3; osc_edge = 1'b1;

    // R4 fires with clip: err 10 > thr 9, limit 4
    cfg_target = 16'd50; cfg_step_div = 16'd4; cfg_up_thresh = 8'd9; cfg_up_limit = 8'd4;
    do_reset(); at_point(1); expect_eval("up clip", 10);
    chk("R8 irq2 with up", irq, 3'b101);
    // R4 boundary: err equal to threshold, no request
    cfg_up_thresh = 8'd10; cfg_up_limit = 8'd255;
    do_reset(); at_point(1); expect_eval("up boundary", 10);
    chk("R4 no fire at threshold", irq, 0);

    // R5 down: count 10, target 2 -> err 8
    cfg_target = 16'd2; cfg_step_div = 16'd1; cfg_dn_thresh = 8'd7; cfg_dn_limit = 8'd8;
    do_reset(); at_point(1); expect_eval("down", 10);
    chk("R5 down line", irq, 3'b010);
    cfg_dn_thresh = 8'd8;
    do_reset(); at_point(1); chk("R5 no fire at threshold", irq, 0);
    chk("R5 err stat", stat_err, 8);

    // R3 divisor zero acts as one
    cfg_target = 16'd13; cfg_step_div = 16'd0; cfg_up_thresh = 8'd0;
    do_reset(); at_point(1); expect_eval("div zero", 10);

    // R2 osc low -> count 0
    osc_edge = 1'b0; cfg_target = 16'd6; cfg_step_div = 16'd1; cfg_up_thresh = 8'd20;
    do_reset(); at_point(1); chk("R2 zero count err", stat_err, 6);
    osc_edge = 1'b1;

    // R6 consecutive count 2 -> fires on third qualifying interval
    cfg_target = 16'd50; cfg_step_div = 16'd4; cfg_up_thresh = 8'd0; cfg_up_cons = 4'd2;
    do_reset();
    at_point(1); chk("R6 cons interval1", irq, 0);
    at_point(2); chk("R6 cons interval2", irq, 0);
    at_point(3); chk("R6 cons interval3", irq, 3'b001);

    // R6 a non-qualifying interval restarts the run
    cfg_up_cons = 4'd1;
    do_reset();
    at_point(1); chk("R6 run start", irq, 0); cfg_target = 16'd10;
    at_point(2); chk("R6 break", irq, 0);     cfg_target = 16'd50;
    at_point(3); chk("R6 restart no early fire", irq, 0);
    at_point(4); chk("R6 fire after restart", irq, 3'b001);

    // R7 masking while pending, then clear
    cfg_up_cons = 4'd0; cfg_target = 16'd30; cfg_step_div = 16'd4;
    cfg_dn_thresh = 8'd0;
    at_point(5); chk("R7 held irq", irq, 3'b001); chk("R7 held err", stat_err, 10);
    cfg_target = 16'd0;
    at_point(6); chk("R7 masked irq", irq, 3'b001); chk("R7 masked err", stat_err, 10);
    chk("R7 masked dir", stat_up, 1);
    clear_all(); #1; chk("R7 cleared", irq, 0);
    at_point(7); chk("R7 after clear down", irq, 3'b010); chk("R7 after clear err", stat_err, 2);

    // Random configurations against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 30; i++) begin
      int cnt;
      cfg_idle_clks = 8'($urandom_range(0, 5));
      cfg_gate_us   = 16'($urandom_range(1, 20));
      cfg_target    = 16'($urandom_range(0, 40));
      cfg_step_div  = 16'($urandom_range(0, 5));
      cfg_up_thresh = 8'($urandom_range(0, 7));
      cfg_dn_thresh = 8'($urandom_range(0, 7));
      cfg_up_limit  = 8'($urandom_range(0, 15));
      cfg_dn_limit  = 8'($urandom_range(0, 15));
      osc_edge      = ($urandom_range(0, 3) != 0);
      cnt = osc_edge ? int'(cfg_gate_us) : 0;
      do_reset(); at_point(1);
      expect_eval($sformatf("rand%0d", i), cnt);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule